// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Detector

This block watches 32 general-purpose input lines and turns chosen conditions on them into interrupt requests. The lines form two banks of 16: lines 0 to 15 are the low bank and lines 16 to 31 the high bank. Every control register exists as a pair, and the high half of each pair sits 2 bytes above the low half. Software sets up each line on a 16-bit register bus. It chooses between level and edge sensing, the polarity that counts as active for level sensing, and which edges count for edge sensing. It also chooses whether a detected event is held until acknowledged or is passed straight through.

Each input first passes through a two-flop synchroniser. Detection then runs on the synchronised value. Detected events land in per-line status bits. A status bit is gated by its enable bit, and the gated bits are ORed into one interrupt request. A pending-index output gives the lowest-numbered enabled line that is pending, so the low bank always wins over the high bank. Software acknowledges a held event by writing a one to its status bit.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the enable, status and trigger-type registers read 0. The polarity and both edge-select registers read 0xFFFF. `irqOut` and `pendValid` are 0.
- R2: Registers sit at these byte offsets, each pair given as low bank / high bank: status 0x08/0x0A, enable 0x0C/0x0E, trigger type 0x10/0x12, polarity 0x14/0x16, hold 0x18/0x1A, falling select 0x20/0x22, rising select 0x24/0x26. Bit k of a register maps to line k (low bank) or line 16+k (high bank). Configuration registers read back what was written. Any other address reads 0, and writes to it change nothing.
- R3: A change on `lineIn` driven before a rising clock edge shows up in status on the third rising edge counted from that one, and not sooner.
- R4: With trigger type bit 0 (level), the line's condition is true while the synchronised input equals its polarity bit: 1 means active high, 0 means active low.
- R5: With trigger type bit 1 (edge), a rising transition counts only when the rising-select bit is 1, and a falling transition counts only when the falling-select bit is 1. Setting both bits detects both edges. A steady input never counts.
- R6: With hold bit 1, a detected condition sets the status bit, and the bit stays set until a 1 is written to it in the status register. Writing 0 leaves it unchanged.
- R7: With hold bit 0, the status bit follows the line's detected condition every cycle. A write-one-to-clear has no lasting effect on it.
- R8: `irqOut` is the OR over all lines of (status AND enable). Status bits are still captured and readable while their enable bit is 0.
- R9: `pendIdx` gives the lowest-numbered line whose status and enable bits are both 1, and `pendValid` marks that such a line exists. A pending low-bank line is therefore reported before any high-bank line.
- R10: If a new event and a write-one-to-clear reach the same held status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 6 | Register byte address |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data of the addressed register, combinational |
| lineIn | input | 32 | Asynchronous input lines |
| irqOut | output | 1 | Summary interrupt request |
| pendValid | output | 1 | At least one enabled line is pending |
| pendIdx | output | 5 | Lowest-numbered enabled pending line |

## Verification
The bound checker tests these properties on every cycle:
- the summary request agrees with the pending-valid flag;
- the reported index is a live line with no lower live line below it;
- a held status bit never drops unless its clear bit was written;
- enable and status are zero in the first cycle after reset.

Some behaviours only the bench's scenarios can show:
- the three-edge synchroniser latency;
- the edge-select choices and the active-low and active-high level choices;
- pass-through status following the input;
- the event-beats-clear collision;
- register readback and the unmapped-address cases.

These need stimulus timed against the input lines and values worked out from the requirements.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W    = 6;
  localparam int NUM_BANKS = 2;

  // base offsets of the low-bank register of each pair; high bank is +2
  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_EN   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_TYPE = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_POL  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_HOLD = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_FALL = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_RISE = 6'h24;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_EN,
    SEL_TYPE,
    SEL_POL,
    SEL_HOLD,
    SEL_FALL,
    SEL_RISE
  } regSel_e;

  // strobes from the control decode to the datapath
  typedef struct packed {
    regSel_e sel;
    logic    bank;
    logic    wrStb;
  } busStb_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStb_t           stb
);

  logic [ADDR_W-1:0] pairBase;
  regSel_e           selDec;

  assign pairBase = {busAddr[ADDR_W-1:2], 2'b00};

  always_comb begin
    selDec = SEL_NONE;
    if (!busAddr[0]) begin
      unique case (pairBase)
        OFF_STAT: selDec = SEL_STAT;
        OFF_EN:   selDec = SEL_EN;
        OFF_TYPE: selDec = SEL_TYPE;
        OFF_POL:  selDec = SEL_POL;
        OFF_HOLD: selDec = SEL_HOLD;
        OFF_FALL: selDec = SEL_FALL;
        OFF_RISE: selDec = SEL_RISE;
        default:  selDec = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    stb.sel   = selDec;
    stb.bank  = busAddr[1];
    stb.wrStb = busWrEn && (selDec != SEL_NONE);
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int BANK_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  busStb_t                       stb,
  input  logic [BANK_W-1:0]             busWrData,
  output logic [BANK_W-1:0]             busRdData,
  input  logic [NUM_BANKS*BANK_W-1:0]   lineIn,
  output logic [NUM_BANKS*BANK_W-1:0]   statusVec,
  output logic [NUM_BANKS*BANK_W-1:0]   enableVec,
  output logic [NUM_BANKS*BANK_W-1:0]   holdVec
);

  localparam int NL = NUM_BANKS * BANK_W;

  logic [NL-1:0] enQ, typeQ, polQ, holdQ, fallQ, riseQ, statQ;
  logic [SYNC_STAGES-1:0][NL-1:0] syncChain;
  logic [NL-1:0] prevLvl, syncLvl;
  logic [NL-1:0] bankMask, wrData, clrMask;
  logic [NL-1:0] riseHit, fallHit, edgeHit, levelHit, condVec, statNext;
  logic [NL-1:0] rdVec;

  // per-bank byte-lane select for the addressed half of a pair
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankMask[b*BANK_W +: BANK_W] = {BANK_W{stb.bank == b[0]}};
    assign wrData[b*BANK_W +: BANK_W]   = busWrData;
  end

  function automatic logic [NL-1:0] mergeWr(input logic [NL-1:0] oldVal);
    return (oldVal & ~bankMask) | (wrData & bankMask);
  endfunction

  assign clrMask = (stb.wrStb && stb.sel == SEL_STAT) ? (wrData & bankMask) : '0;

  // detection on the synchronised level
  assign syncLvl  = syncChain[SYNC_STAGES-1];
  assign riseHit  = syncLvl & ~prevLvl & riseQ;
  assign fallHit  = ~syncLvl & prevLvl & fallQ;
  assign edgeHit  = riseHit | fallHit;
  assign levelHit = ~(syncLvl ^ polQ);
  assign condVec  = (typeQ & edgeHit) | (~typeQ & levelHit);
  // held bits: event wins over a same-cycle clear; pass-through bits follow condition
  assign statNext = (holdQ & ((statQ & ~clrMask) | condVec)) | (~holdQ & condVec);

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ       <= '0;
      typeQ     <= '0;
      polQ      <= '1;
      holdQ     <= '0;
      fallQ     <= '1;
      riseQ     <= '1;
      statQ     <= '0;
      syncChain <= '0;
      prevLvl   <= '0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], lineIn};
      prevLvl   <= syncLvl;
      statQ     <= statNext;
      if (stb.wrStb) begin
        unique case (stb.sel)
          SEL_EN:   enQ   <= mergeWr(enQ);
          SEL_TYPE: typeQ <= mergeWr(typeQ);
          SEL_POL:  polQ  <= mergeWr(polQ);
          SEL_HOLD: holdQ <= mergeWr(holdQ);
          SEL_FALL: fallQ <= mergeWr(fallQ);
          SEL_RISE: riseQ <= mergeWr(riseQ);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (stb.sel)
      SEL_STAT: rdVec = statQ;
      SEL_EN:   rdVec = enQ;
      SEL_TYPE: rdVec = typeQ;
      SEL_POL:  rdVec = polQ;
      SEL_HOLD: rdVec = holdQ;
      SEL_FALL: rdVec = fallQ;
      SEL_RISE: rdVec = riseQ;
      default:  rdVec = '0;
    endcase
  end

  assign busRdData = stb.bank ? rdVec[NL-1 -: BANK_W] : rdVec[BANK_W-1:0];
  assign statusVec = statQ;
  assign enableVec = enQ;
  assign holdVec   = holdQ;

endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
  parameter int NL    = 32,
  parameter int IDX_W = 5
) (
  input  logic [NL-1:0]    liveVec,
  output logic [IDX_W-1:0] pendIdx,
  output logic             pendValid
);

  always_comb begin
    pendIdx   = '0;
    pendValid = 1'b0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (liveVec[i]) begin
        pendIdx   = i[IDX_W-1:0];
        pendValid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int BANK_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWrEn,
  input  logic [BANK_W-1:0]           busWrData,
  output logic [BANK_W-1:0]           busRdData,
  input  logic [NUM_BANKS*BANK_W-1:0] lineIn,
  output logic                        irqOut,
  output logic                        pendValid,
  output logic [$clog2(NUM_BANKS*BANK_W)-1:0] pendIdx
);

  localparam int NL    = NUM_BANKS * BANK_W;
  localparam int IDX_W = $clog2(NL);

  busStb_t       stb;
  logic [NL-1:0] statusVec, enableVec, holdVec, liveVec;

  gpio_irq_ctrl ctrl_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .stb     (stb)
  );

  gpio_irq_datapath #(
    .BANK_W      (BANK_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .lineIn    (lineIn),
    .statusVec (statusVec),
    .enableVec (enableVec),
    .holdVec   (holdVec)
  );

  assign liveVec = statusVec & enableVec;
  assign irqOut  = |liveVec;

  gpio_irq_prio #(
    .NL    (NL),
    .IDX_W (IDX_W)
  ) prio_i (
    .liveVec   (liveVec),
    .pendIdx   (pendIdx),
    .pendValid (pendValid)
  );

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
#(
  parameter int NL    = 32,
  parameter int IDX_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [NL/2-1:0]   busWrData,
  input logic              irqOut,
  input logic              pendValid,
  input logic [IDX_W-1:0]  pendIdx,
  input logic [NL-1:0]     statusVec,
  input logic [NL-1:0]     enableVec,
  input logic [NL-1:0]     holdVec
);

  logic [NL-1:0] liveVec, lowerMask, clrMask, keepVec;
  logic          statWr;

  assign liveVec   = statusVec & enableVec;
  assign lowerMask = ({{(NL-1){1'b0}}, 1'b1} << pendIdx) - 1'b1;
  assign statWr    = busWrEn && !busAddr[0] && ({busAddr[ADDR_W-1:2], 2'b00} == OFF_STAT);
  assign clrMask   = !statWr ? '0 :
                     (busAddr[1] ? {busWrData, {(NL/2){1'b0}}} : {{(NL/2){1'b0}}, busWrData});
  assign keepVec   = statusVec & holdVec & ~clrMask;

  // R1: first cycle out of reset sees clean enable and status
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (enableVec == '0 && statusVec == '0));

  // R8: summary request and pending flag come from separate logic and must agree
  assert_irq_matches_R8: assert property (@(posedge clk) disable iff (rst)
    irqOut == pendValid);

  // R9: reported index is live and nothing lower is live
  assert_lowest_index_R9: assert property (@(posedge clk) disable iff (rst)
    pendValid |-> (liveVec[pendIdx] && ((liveVec & lowerMask) == '0)));

  // R6: held bits drop only when their clear bit is written
  assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(keepVec) & ~statusVec) == '0));

endmodule

bind gpio_irq_detect gpio_irq_checker #(
  .NL    (NL),
  .IDX_W (IDX_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .irqOut    (irqOut),
  .pendValid (pendValid),
  .pendIdx   (pendIdx),
  .statusVec (statusVec),
  .enableVec (enableVec),
  .holdVec   (holdVec)
);

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/100ps
module gpio_irq_detect_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [31:0] lineIn = 32'h0000_0010;
  logic        irqOut, pendValid;
  logic [4:0]  pendIdx;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio_irq_detect dut_i (
    .clk       (clk),
    .rst       (rst),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .lineIn    (lineIn),
    .irqOut    (irqOut),
    .pendValid (pendValid),
    .pendIdx   (pendIdx)
  );

  typedef struct packed {
    logic [31:0] lines;
    logic [31:0] expStat;
  } vec_t;

  // lines 0..4, 17, 20 configured below; held bits accumulate along the walk
  localparam vec_t VECS [0:11] = '{
    '{32'h0000_0010, 32'h0000_0000},
    '{32'h0000_0011, 32'h0000_0001},
    '{32'h0000_0013, 32'h0000_0001},
    '{32'h0000_0011, 32'h0000_0003},
    '{32'h0000_0015, 32'h0000_0007},
    '{32'h0000_001D, 32'h0000_000F},
    '{32'h0000_0015, 32'h0000_0007},
    '{32'h0000_0005, 32'h0000_0017},
    '{32'h0002_0005, 32'h0002_0017},
    '{32'h0000_0005, 32'h0002_0017},
    '{32'h0010_0005, 32'h0012_0017},
    '{32'h0000_0015, 32'h0012_0007}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic readStatus(output logic [31:0] s);
    logic [15:0] lo, hi;
    busRead(6'h08, lo);
    busRead(6'h0A, hi);
    s = {hi, lo};
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    logic [31:0] st;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset values
    chk("R1 irq", {31'b0, irqOut}, 32'h0);
    chk("R1 valid", {31'b0, pendValid}, 32'h0);
    busRead(6'h10, rd); chk("R1 type lo", {16'b0, rd}, 32'h0);
    busRead(6'h0E, rd); chk("R1 enable hi", {16'b0, rd}, 32'h0);
    busRead(6'h24, rd); chk("R1 rise lo", {16'b0, rd}, 32'h0000_FFFF);
    busRead(6'h16, rd); chk("R1 pol hi", {16'b0, rd}, 32'h0000_FFFF);

    // configuration
    busWrite(6'h10, 16'h0007);   // lines 0..2 edge
    busWrite(6'h12, 16'h0010);   // line 20 edge
    busWrite(6'h14, 16'hFFEF);   // line 4 active low
    busWrite(6'h18, 16'h0007);   // hold lines 0..2
    busWrite(6'h1A, 16'h0012);   // hold lines 17, 20
    busWrite(6'h24, 16'hFFFD);   // line 1 no rising
    busWrite(6'h20, 16'hFFFE);   // line 0 no falling
    busWrite(6'h22, 16'hFFEF);   // line 20 no falling
    busWrite(6'h08, 16'hFFFF);
    busWrite(6'h0A, 16'hFFFF);
    repeat (4) @(posedge clk);

    // R4 R5 R6 R7 R11: table walk
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) lineIn = VECS[i].lines;
      repeat (3) @(posedge clk);
      readStatus(st);
      chk($sformatf("R4/R5/R6/R7 vector %0d", i), st, VECS[i].expStat);
    end
    // R8: captured while masked, but no request
    chk("R8 masked no irq", {31'b0, irqOut}, 32'h0);

    // R6 write-zero leaves, write-one clears
    busWrite(6'h08, 16'h0000);
    busRead(6'h08, rd); chk("R6 write zero keeps", {16'b0, rd}, 32'h0007);
    busWrite(6'h08, 16'h0001);
    busRead(6'h08, rd); chk("R6 w1c clears", {16'b0, rd}, 32'h0006);

    // R8 R9 enable gating and priority
    busWrite(6'h0E, 16'h0002);
    chk("R8 irq on", {31'b0, irqOut}, 32'h1);
    chk("R9 idx high bank", {27'b0, pendIdx}, 32'd17);
    busWrite(6'h0C, 16'h0004);
    chk("R9 idx line2", {27'b0, pendIdx}, 32'd2);
    busWrite(6'h0C, 16'h0006);
    chk("R9 idx lowest", {27'b0, pendIdx}, 32'd1);
    chk("R9 valid", {31'b0, pendValid}, 32'h1);
    busWrite(6'h08, 16'h0006);
    chk("R9 low first then high", {27'b0, pendIdx}, 32'd17);
    busWrite(6'h0A, 16'h0002);
    chk("R8 line20 pending but masked", {31'b0, irqOut}, 32'h0);
    chk("R9 valid drops", {31'b0, pendValid}, 32'h0);

    // R10 event and clear in the same cycle
    @(negedge clk) lineIn = 32'h0000_0011;
    repeat (2) @(posedge clk);
    @(negedge clk);
    busAddr = 6'h08; busWrData = 16'h0004; busWrEn = 1'b1;
    @(negedge clk) busWrEn = 1'b0;
    busRead(6'h08, rd); chk("R10 event wins", {16'b0, rd}, 32'h0004);
    busWrite(6'h08, 16'h0004);
    busRead(6'h08, rd); chk("R6 clear after collision", {16'b0, rd}, 32'h0000);

    // R3 latency on level line 3
    @(negedge clk) lineIn = 32'h0000_0019;
    repeat (2) @(posedge clk);
    busRead(6'h08, rd); chk("R3 not after two edges", {16'b0, rd}, 32'h0000);
    @(posedge clk);
    busRead(6'h08, rd); chk("R3 set on third edge", {16'b0, rd}, 32'h0008);

    // R7 clearing a pass-through bit has no lasting effect
    busWrite(6'h08, 16'h0008);
    busRead(6'h08, rd); chk("R7 through ignores w1c", {16'b0, rd}, 32'h0008);

    // R2 readback and unmapped addresses
    busRead(6'h10, rd); chk("R2 type lo", {16'b0, rd}, 32'h0007);
    busRead(6'h22, rd); chk("R2 fall hi", {16'b0, rd}, 32'h0000_FFEF);
    busRead(6'h1A, rd); chk("R2 hold hi", {16'b0, rd}, 32'h0012);
    busRead(6'h0E, rd); chk("R2 enable hi", {16'b0, rd}, 32'h0002);
    busWrite(6'h1C, 16'hFFFF);
    busRead(6'h1C, rd); chk("R2 unmapped reads zero", {16'b0, rd}, 32'h0);
    busRead(6'h0C, rd); chk("R2 unmapped write harmless", {16'b0, rd}, 32'h0006);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule